// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block lets software reach a bank of 8-bit PHY delay registers through a single 32-bit control word. Software places a register address and a byte of write data in the word, then raises one of two strobe bits. The port starts a request/acknowledge exchange with the PHY-side register file. It reports completion through an acknowledge bit that software reads back from the same word. For a read, the returned byte shows up in a read-data field of the control word.

The exchange is four-phase. A strobe rising starts exactly one PHY access. The acknowledge bit then rises and stays high until software clears the strobe, and it falls a few cycles later. Only after that does the next access begin. The PHY side is modelled as a register file that answers after a fixed, parameterised number of cycles. Its implemented address set is selected by a mask parameter. Addresses outside that set accept writes without storing them and read back as zero.

Top module: `phy_access_port`

## Requirements
- R1: After reset the control word reads back as 0 and every implemented PHY register holds 0.
- R2: A host write updates only the address field (bits 5:0), the write-data field (bits 15:8), the write strobe (bit 24) and the read strobe (bit 25). Host writes to the read-data field (bits 23:16), the acknowledge bit (bit 26) and bits 31:27, 7:6 have no effect, and those last bits read back as 0.
- R3: Setting the write strobe stores the write-data byte in the addressed PHY register, and the acknowledge bit reads 1 within RESP_DLY+3 cycles of that host write.
- R4: The acknowledge bit stays 1 for as long as the strobe is held, and reads 0 within 3 cycles after the host write that clears both strobes.
- R5: Each rising edge of a strobe performs exactly one PHY access. The access uses the address and data present when the strobe rose. Holding or rewriting the control word with the strobe still set neither repeats the access nor changes its target.
- R6: Setting the read strobe loads the addressed PHY register into bits 23:16. The value is already valid on the first cycle in which the acknowledge bit reads 1.
- R7: When both strobes are set together, the access is a write, and the read-data field keeps its previous value.
- R8: Implemented PHY addresses are 0x00–0x08 and 0x0B–0x0D. Writes to any other address are acknowledged but discarded, and reads from them return 0.
- R9: The read-data field holds the result of the last completed read until another read completes. Write accesses leave it unchanged.
- R10: A write to one PHY register leaves every other PHY register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_we | input | 1 | Host write enable for the control word |
| cw_wdata | input | 32 | Host write value for the control word |
| cw_rdata | output | 32 | Control word readback: address, write data, read data, strobes, acknowledge |

## Verification
The embedded assertions check the handshake on every cycle. They check that the acknowledge bit rises only after the PHY answered and stays up while a strobe is held. They check that the request toward the PHY keeps a stable address, data and direction while it is raised. They also check that a single transaction never writes the PHY storage twice and that unimplemented addresses answer zero. The bench scenarios are what show the stored values. These cover read-back after many writes, the independence of registers, and the first-captured address winning when the word is rewritten mid-transaction. They also cover the write taking priority over a simultaneous read, and the read-data field persisting across writes.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;

    // Control-word geometry
    localparam int CW_W      = 32;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int NREGS     = 1 << ADDR_W;
    localparam int ADDR_LSB  = 0;
    localparam int WDATA_LSB = 8;
    localparam int RDATA_LSB = 16;
    localparam int WSTB_BIT  = 24;
    localparam int RSTB_BIT  = 25;
    localparam int ACK_BIT   = 26;

    // Host-side handshake phases
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_HOLD = 2'd2,
        HS_DROP = 2'd3
    } hs_state_e;

    // PHY model phases
    typedef enum logic [1:0] {
        PM_IDLE = 2'd0,
        PM_BUSY = 2'd1,
        PM_DONE = 2'd2
    } pm_state_e;

endpackage

// File: rtl/phy_port_cw.sv
// Control-word register: holds the software-owned fields and assembles the
// readback word from them plus the handshake-owned fields.
module phy_port_cw
    import phy_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_we,
    input  logic [CW_W-1:0]   cw_wdata,
    input  logic              hs_ack,
    input  logic [DATA_W-1:0] hs_rd,
    output logic [CW_W-1:0]   cw_rdata,
    output logic [ADDR_W-1:0] sw_addr,
    output logic [DATA_W-1:0] sw_wdata,
    output logic              sw_wstb,
    output logic              sw_rstb
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wstb;
        logic              rstb;
    } cw_regs_t;

    cw_regs_t cw_d, cw_q;

    always_comb begin
        cw_d = cw_q;
        if (cw_we) begin
            cw_d.addr  = cw_wdata[ADDR_LSB +: ADDR_W];
            cw_d.wdata = cw_wdata[WDATA_LSB +: DATA_W];
            cw_d.wstb  = cw_wdata[WSTB_BIT];
            cw_d.rstb  = cw_wdata[RSTB_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cw_q <= '0;
        else        cw_q <= cw_d;
    end

    // Readback assembly; unassigned positions read as zero.
    always_comb begin
        cw_rdata                            = '0;
        cw_rdata[ADDR_LSB  +: ADDR_W]       = cw_q.addr;
        cw_rdata[WDATA_LSB +: DATA_W]       = cw_q.wdata;
        cw_rdata[RDATA_LSB +: DATA_W]       = hs_rd;
        cw_rdata[WSTB_BIT]                  = cw_q.wstb;
        cw_rdata[RSTB_BIT]                  = cw_q.rstb;
        cw_rdata[ACK_BIT]                   = hs_ack;
    end

    assign sw_addr  = cw_q.addr;
    assign sw_wdata = cw_q.wdata;
    assign sw_wstb  = cw_q.wstb;
    assign sw_rstb  = cw_q.rstb;

    // Read-only and reserved positions of the host write value.
    logic unused_cw_bits;
    assign unused_cw_bits = ^{cw_wdata[CW_W-1:ACK_BIT],
                              cw_wdata[RDATA_LSB +: DATA_W],
                              cw_wdata[WDATA_LSB-1:ADDR_LSB+ADDR_W]};

endmodule

// File: rtl/phy_port_hs.sv
// Host-side four-phase handshake toward the PHY register file.
module phy_port_hs
    import phy_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wstb,
    input  logic              sw_rstb,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              hs_ack,
    output logic [DATA_W-1:0] hs_rd,
    output logic              req,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata
);

    typedef struct packed {
        hs_state_e         st;
        logic              ack;
        logic [DATA_W-1:0] rd;
        logic              req;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } hs_regs_t;

    hs_regs_t hs_d, hs_q;
    logic     any_stb;

    assign any_stb = sw_wstb | sw_rstb;

    always_comb begin
        hs_d = hs_q;
        unique case (hs_q.st)
            HS_IDLE: begin
                // Strobe seen from idle is a fresh rising edge; latch the target.
                if (any_stb) begin
                    hs_d.req   = 1'b1;
                    hs_d.wr    = sw_wstb;      // write wins over read
                    hs_d.addr  = sw_addr;
                    hs_d.wdata = sw_wdata;
                    hs_d.st    = HS_REQ;
                end
            end
            HS_REQ: begin
                if (phy_ack) begin
                    hs_d.ack = 1'b1;
                    if (!hs_q.wr) hs_d.rd = phy_rdata;
                    hs_d.st  = HS_HOLD;
                end
            end
            HS_HOLD: begin
                if (!any_stb) begin
                    hs_d.req = 1'b0;
                    hs_d.st  = HS_DROP;
                end
            end
            HS_DROP: begin
                if (!phy_ack) begin
                    hs_d.ack = 1'b0;
                    hs_d.st  = HS_IDLE;
                end
            end
            default: hs_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '{st: HS_IDLE, default: '0};
        else        hs_q <= hs_d;
    end

    assign hs_ack    = hs_q.ack;
    assign hs_rd     = hs_q.rd;
    assign req       = hs_q.req;
    assign req_wr    = hs_q.wr;
    assign req_addr  = hs_q.addr;
    assign req_wdata = hs_q.wdata;

    // R3: the software-visible acknowledge only rises after the PHY answered.
    a_r3_ack_after_phy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_ack) |-> $past(phy_ack));

    // R4: acknowledge is held while the strobe stays up after completion.
    a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ack && hs_q.st == HS_HOLD && any_stb) |=> hs_ack);

    // R5: the request target cannot move while the request is raised.
    a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req)) |-> ($stable(req_addr) && $stable(req_wdata) && $stable(req_wr)));

endmodule

// File: rtl/phy_regfile_model.sv
// Behavioural PHY delay-register file answering a four-phase request after a
// fixed response delay. Only addresses flagged in IMPL_MASK hold storage.
module phy_regfile_model
    import phy_port_pkg::*;
#(
    parameter int               RESP_DLY  = 3,
    parameter logic [NREGS-1:0] IMPL_MASK = 64'h0000_0000_0000_39FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              phy_ack,
    output logic [DATA_W-1:0] phy_rdata
);

    localparam int CNT_W = $clog2(RESP_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESP_DLY - 1);

    typedef struct packed {
        pm_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } pm_regs_t;

    pm_regs_t                 pm_d, pm_q;
    logic                     wr_fire;
    logic [NREGS*DATA_W-1:0]  mem_flat;
    logic [DATA_W-1:0]        rd_val;

    assign rd_val = mem_flat[int'(req_addr)*DATA_W +: DATA_W];

    always_comb begin
        pm_d    = pm_q;
        wr_fire = 1'b0;
        unique case (pm_q.st)
            PM_IDLE: begin
                if (req) begin
                    pm_d.cnt = '0;
                    pm_d.st  = PM_BUSY;
                end
            end
            PM_BUSY: begin
                if (pm_q.cnt == CNT_LAST) begin
                    pm_d.ack = 1'b1;
                    pm_d.st  = PM_DONE;
                    if (req_wr) wr_fire    = 1'b1;
                    else        pm_d.rdata = rd_val;
                end else begin
                    pm_d.cnt = pm_q.cnt + 1'b1;
                end
            end
            PM_DONE: begin
                if (!req) begin
                    pm_d.ack = 1'b0;
                    pm_d.st  = PM_IDLE;
                end
            end
            default: pm_d.st = PM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pm_q <= '{st: PM_IDLE, default: '0};
        else        pm_q <= pm_d;
    end

    // One storage byte per implemented address; holes read as zero.
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (IMPL_MASK[i]) begin : g_impl
            logic [DATA_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                     val_q <= '0;
                else if (wr_fire && req_addr == ADDR_W'(i))     val_q <= req_wdata;
            end
            assign mem_flat[i*DATA_W +: DATA_W] = val_q;
        end else begin : g_hole
            assign mem_flat[i*DATA_W +: DATA_W] = '0;
        end
    end

    assign phy_ack   = pm_q.ack;
    assign phy_rdata = pm_q.rdata;

    // R5: a single transaction commits its write once only.
    a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

    // R3: the PHY acknowledge answers a raised request.
    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ack) |-> $past(req));

    // R8: a read from a hole returns zero.
    a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_ack) && !req_wr && !IMPL_MASK[req_addr]) |-> phy_rdata == '0);

endmodule

// File: rtl/phy_access_port.sv
// Top: control word, handshake and PHY register file model.
module phy_access_port
    import phy_port_pkg::*;
#(
    parameter int               RESP_DLY  = 3,
    parameter logic [NREGS-1:0] IMPL_MASK = 64'h0000_0000_0000_39FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cw_we,
    input  logic [CW_W-1:0] cw_wdata,
    output logic [CW_W-1:0] cw_rdata
);

    logic              hs_ack;
    logic [DATA_W-1:0] hs_rd;
    logic [ADDR_W-1:0] sw_addr;
    logic [DATA_W-1:0] sw_wdata;
    logic              sw_wstb;
    logic              sw_rstb;
    logic              req;
    logic              req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              phy_ack;
    logic [DATA_W-1:0] phy_rdata;

    phy_port_cw u_cw (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_we    (cw_we),
        .cw_wdata (cw_wdata),
        .hs_ack   (hs_ack),
        .hs_rd    (hs_rd),
        .cw_rdata (cw_rdata),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .sw_wstb  (sw_wstb),
        .sw_rstb  (sw_rstb)
    );

    phy_port_hs u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wstb   (sw_wstb),
        .sw_rstb   (sw_rstb),
        .sw_addr   (sw_addr),
        .sw_wdata  (sw_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .hs_ack    (hs_ack),
        .hs_rd     (hs_rd),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata)
    );

    phy_regfile_model #(
        .RESP_DLY  (RESP_DLY),
        .IMPL_MASK (IMPL_MASK)
    ) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata)
    );

endmodule

// File: tb/phy_access_port_test.sv
module phy_access_port_test;

    localparam int          RESP_DLY  = 3;
    localparam logic [63:0] IMPL_MASK = 64'h0000_0000_0000_39FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_we = 1'b0;
    logic [31:0] cw_wdata = '0;
    logic [31:0] cw_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] model [64];

    typedef struct packed {
        logic [5:0] a;
        logic [7:0] v;
    } exp_t;
    exp_t exp_q [$];

    always #5 clk = ~clk;

    phy_access_port #(.RESP_DLY(RESP_DLY), .IMPL_MASK(IMPL_MASK)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_we    (cw_we),
        .cw_wdata (cw_wdata),
        .cw_rdata (cw_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] a, input logic [7:0] d,
                                       input bit w, input bit r);
        return {5'b0, 1'b0, r, w, 8'h00, d, 2'b00, a};
    endfunction

    task automatic cw_put(input logic [31:0] word);
        @(negedge clk);
        cw_we    = 1'b1;
        cw_wdata = word;
        @(negedge clk);
        cw_we    = 1'b0;
    endtask

    task automatic wait_ack(input bit level, input string req, input int bound);
        int n = 0;
        while (cw_rdata[26] != level && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(cw_rdata[26] == level && n <= bound, req, "acknowledge timing",
              n, bound);
    endtask

    task automatic phy_write(input logic [5:0] a, input logic [7:0] d);
        cw_put(mk(a, d, 1'b0, 1'b0));
        cw_put(mk(a, d, 1'b1, 1'b0));
        wait_ack(1'b1, "R3", RESP_DLY + 3);
        cw_put(mk(a, d, 1'b0, 1'b0));
        wait_ack(1'b0, "R4", 3);
        if (IMPL_MASK[a]) model[a] = d;
    endtask

    task automatic phy_read(input logic [5:0] a);
        exp_t e;
        e.a = a;
        e.v = IMPL_MASK[a] ? model[a] : 8'h00;
        exp_q.push_back(e);
        cw_put(mk(a, 8'h00, 1'b0, 1'b0));
        cw_put(mk(a, 8'h00, 1'b0, 1'b1));
        wait_ack(1'b1, "R6", RESP_DLY + 3);
        cw_put(mk(a, 8'h00, 1'b0, 1'b0));
        wait_ack(1'b0, "R4", 3);
    endtask

    // Monitor: compares the read field on the first cycle acknowledge is seen.
    logic prev_ack = 1'b0;
    always @(negedge clk) begin
        if (rst_n && cw_rdata[26] && !prev_ack && cw_rdata[25] && !cw_rdata[24]) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected read completion", cw_rdata[23:16], 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cw_rdata[23:16] == e.v, "R6", $sformatf("read data addr 0x%0h", e.a),
                      cw_rdata[23:16], e.v);
            end
        end
        prev_ack <= cw_rdata[26];
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset readback
        check(cw_rdata == 32'h0, "R1", "control word after reset", cw_rdata, 0);
        phy_read(6'h0C);   // R1: implemented register is zero after reset
        phy_read(6'h00);

        // R2: read-only and reserved bits ignored, no strobe started
        cw_put(32'hFCFF_FFFF);
        check(cw_rdata == 32'h0000_FF3F, "R2", "readback after all-ones write",
              cw_rdata, 32'h0000_FF3F);
        repeat (RESP_DLY + 4) @(negedge clk);
        check(cw_rdata[26] == 1'b0, "R2", "no acknowledge without strobe", cw_rdata[26], 0);
        cw_put(32'h0);

        // R3 / R10: fill every implemented register with distinct data
        for (int a = 0; a < 14; a++) begin
            if (IMPL_MASK[a]) phy_write(6'(a), 8'(a * 17 + 3));
        end
        for (int a = 0; a < 14; a++) phy_read(6'(a));

        // R8: holes discard writes and read zero
        phy_write(6'h09, 8'hA5);
        phy_write(6'h20, 8'h3C);
        phy_write(6'h3F, 8'hFF);
        phy_read(6'h09);
        phy_read(6'h0A);
        phy_read(6'h3F);
        phy_read(6'h08);   // R10: neighbour unaffected

        // R9: read field persists across a write
        phy_read(6'h05);
        phy_write(6'h07, 8'h42);
        check(cw_rdata[23:16] == model[5], "R9", "read field after write",
              cw_rdata[23:16], model[5]);

        // R5: rewrite the word while the strobe is held
        cw_put(mk(6'h02, 8'h5A, 1'b0, 1'b0));
        cw_put(mk(6'h02, 8'h5A, 1'b1, 1'b0));
        cw_put(mk(6'h03, 8'hC3, 1'b1, 1'b0));
        wait_ack(1'b1, "R5", RESP_DLY + 3);
        // R4: acknowledge held while strobe stays up
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(cw_rdata[26] == 1'b1, "R4", "acknowledge held", cw_rdata[26], 1);
        end
        cw_put(mk(6'h03, 8'hC3, 1'b1, 1'b0));
        repeat (RESP_DLY + 3) @(negedge clk);
        cw_put(mk(6'h03, 8'hC3, 1'b0, 1'b0));
        wait_ack(1'b0, "R4", 3);
        model[2] = 8'h5A;
        phy_read(6'h02);
        phy_read(6'h03);   // R5: still the value from the fill

        // R7: both strobes together perform a write, read field untouched
        phy_read(6'h05);
        cw_put(mk(6'h06, 8'h77, 1'b0, 1'b0));
        cw_put(mk(6'h06, 8'h77, 1'b1, 1'b1));
        wait_ack(1'b1, "R7", RESP_DLY + 3);
        check(cw_rdata[23:16] == model[5], "R7", "read field with both strobes",
              cw_rdata[23:16], model[5]);
        cw_put(mk(6'h06, 8'h77, 1'b0, 1'b0));
        wait_ack(1'b0, "R4", 3);
        model[6] = 8'h77;
        phy_read(6'h06);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6", "pending expected reads", exp_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule